// File: doc/BRIEF.md
# Single-Shunt Phase Current Reconstructor

This block rebuilds the three motor phase currents from the two readings of a single DC-link shunt resistor taken in one PWM period. Each reading comes in with a tag that says whether it was the first or the second active-vector sample of the sampling half-period. The block also takes the space-vector sector that was active while the readings were taken. The sector decides which phase each reading belongs to. The second reading always shows a phase current with inverted sign. The phase that was not measured is found from the rule that the three phase currents add up to zero.

The period starts at the carrier zero event. At that event the block latches the sector and discards any readings left over from the previous period. At the carrier top event it publishes the three signed phase currents with a one-cycle valid strobe, provided that both readings of the period have arrived. If a reading is missing, the outputs keep their last values and a missing-sample flag is raised for that period. Sign inversion and the derived-phase sum both clamp to the signed output range, so they never wrap.

Top module: `shunt_phase_rebuild`

## Requirements
- R1: The sector in force for a period is the value of `sector_in` at the `zero_evt` cycle. Changes on `sector_in` after that cycle have no effect on the result published at the following top event.
- R2: A sample with `smp_second`=0 is the first reading and one with `smp_second`=1 is the second reading. The two readings may arrive in either order.
- R3: The mapping of readings to phases (first reading → phase; second reading → negated phase; derived phase) is as follows. Sector 1: b; c; a. Sector 2: a; b; c. Sector 3: a; c; b. Sector 4: c; a; b. Sector 5: b; a; c. Sector 6: c; b; a.
- R4: Sector codes 0 and 7 give zero on all three phase outputs.
- R5: The derived phase equals minus the sum of the other two phase outputs, clamped to [-2^(DW-1), 2^(DW-1)-1].
- R6: Negating the second reading clamps the most negative code to the most positive code.
- R7: The phase outputs update, and `out_valid` is high for exactly one cycle, in the cycle after a `top_evt` cycle. This happens only when both readings were received since the last zero or top event.
- R8: When a reading is missing at `top_evt`, `out_valid` stays low and the phase outputs keep their values. `miss_o` goes high in the next cycle and stays high until the next top event that has both readings.
- R9: After reset, all phase outputs are zero and `out_valid` and `miss_o` are low.
- R10: Readings are discarded at every zero event and at every top event, so a reading is never reused in a later period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| zero_evt | input | 1 | Carrier zero event; starts a sampling period |
| top_evt | input | 1 | Carrier top event; requests reconstruction |
| sector_in | input | 3 | Space-vector sector code |
| smp_valid | input | 1 | Shunt reading present this cycle |
| smp_second | input | 1 | 0 = first reading, 1 = second reading |
| smp_data | input | DW | Signed shunt reading |
| ia_o | output | DW | Signed phase a current |
| ib_o | output | DW | Signed phase b current |
| ic_o | output | DW | Signed phase c current |
| out_valid | output | 1 | One-cycle strobe: new phase currents |
| miss_o | output | 1 | A reading was missing at the last top event |

## Verification
The properties assume that the two carrier events never arrive in the same cycle. They also assume that no reading arrives in a cycle that carries an event, because that reading would belong to the next collection. The stimulus opens every period with a lone zero-event cycle and closes it with a lone top-event cycle. Readings are placed strictly between the two, with idle cycles in between. The sum property exempts any result in which a phase sits at a range limit, since clamping breaks the zero-sum there. The directed values push clamping only through the extreme codes.

// File: rtl/spr_pkg.sv
package spr_pkg;

    typedef logic [2:0] sector_t;

    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2
    } phase_e;

    // phase carried by the first active-vector reading
    function automatic phase_e lead_phase(sector_t s);
        case (s)
            3'd1:    return PH_B;
            3'd2:    return PH_A;
            3'd3:    return PH_A;
            3'd4:    return PH_C;
            3'd5:    return PH_B;
            3'd6:    return PH_C;
            default: return PH_A;
        endcase
    endfunction

    // phase whose negated current the second reading carries
    function automatic phase_e trail_phase(sector_t s);
        case (s)
            3'd1:    return PH_C;
            3'd2:    return PH_B;
            3'd3:    return PH_C;
            3'd4:    return PH_A;
            3'd5:    return PH_A;
            3'd6:    return PH_B;
            default: return PH_B;
        endcase
    endfunction

    function automatic logic null_sector(sector_t s);
        return (s == 3'd0) || (s == 3'd7);
    endfunction

endpackage

// File: rtl/spr_sample_store.sv
module spr_sample_store
    import spr_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zero_evt,
    input  logic          top_evt,
    input  sector_t       sector_in,
    input  logic          smp_valid,
    input  logic          smp_second,
    input  logic [DW-1:0] smp_data,
    output sector_t       sec_o,
    output logic [DW-1:0] lead_o,
    output logic [DW-1:0] trail_o,
    output logic          both_o
);

    localparam int NSLOT = 2;

    typedef struct packed {
        sector_t                   sec;
        logic [NSLOT-1:0]          have;
        logic [NSLOT-1:0][DW-1:0]  smp;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (zero_evt) begin
            st_d.sec  = sector_in;
            st_d.have = '0;
        end
        if (top_evt) begin
            st_d.have = '0;
        end
        if (smp_valid) begin
            st_d.smp[smp_second]  = smp_data;
            st_d.have[smp_second] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o   = st_q.sec;
    assign lead_o  = st_q.smp[0];
    assign trail_o = st_q.smp[1];
    assign both_o  = &st_q.have;

endmodule

// File: rtl/spr_phase_map.sv
module spr_phase_map
    import spr_pkg::*;
#(
    parameter int DW = 12
) (
    input  sector_t              sec,
    input  logic signed [DW-1:0] lead,
    input  logic signed [DW-1:0] trail,
    output logic [2:0][DW-1:0]   phase
);

    localparam int EW = DW + 2;
    localparam int NPH = 3;
    localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [EW-1:0] WMAX = {{2{1'b0}}, SMAX};
    localparam logic signed [EW-1:0] WMIN = {{2{1'b1}}, SMIN};

    logic signed [DW-1:0] meas_lead;
    logic signed [DW-1:0] meas_trail;
    logic signed [EW-1:0] wide_sum;
    logic signed [EW-1:0] wide_neg;
    logic signed [DW-1:0] derived;
    phase_e               p_lead;
    phase_e               p_trail;
    logic                 zeroed;

    always_comb begin
        meas_lead  = lead;
        meas_trail = (trail == SMIN) ? SMAX : -trail;
        wide_sum   = {{2{meas_lead[DW-1]}}, meas_lead} + {{2{meas_trail[DW-1]}}, meas_trail};
        wide_neg   = -wide_sum;
        if (wide_neg > WMAX) begin
            derived = SMAX;
        end else if (wide_neg < WMIN) begin
            derived = SMIN;
        end else begin
            derived = wide_neg[DW-1:0];
        end
        p_lead  = lead_phase(sec);
        p_trail = trail_phase(sec);
        zeroed  = null_sector(sec);
    end

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        always_comb begin
            if (zeroed) begin
                phase[g] = '0;
            end else if (p_lead == phase_e'(g)) begin
                phase[g] = meas_lead;
            end else if (p_trail == phase_e'(g)) begin
                phase[g] = meas_trail;
            end else begin
                phase[g] = derived;
            end
        end
    end

endmodule

// File: rtl/shunt_phase_rebuild.sv
module shunt_phase_rebuild
    import spr_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 zero_evt,
    input  logic                 top_evt,
    input  logic [2:0]           sector_in,
    input  logic                 smp_valid,
    input  logic                 smp_second,
    input  logic [DW-1:0]        smp_data,
    output logic signed [DW-1:0] ia_o,
    output logic signed [DW-1:0] ib_o,
    output logic signed [DW-1:0] ic_o,
    output logic                 out_valid,
    output logic                 miss_o
);

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] c;
        logic          vld;
        logic          miss;
    } out_t;

    sector_t           sec_q;
    logic [DW-1:0]     lead_q;
    logic [DW-1:0]     trail_q;
    logic              both_q;
    logic [2:0][DW-1:0] mapped;
    out_t              o_d, o_q;

    spr_sample_store #(.DW(DW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .zero_evt   (zero_evt),
        .top_evt    (top_evt),
        .sector_in  (sector_in),
        .smp_valid  (smp_valid),
        .smp_second (smp_second),
        .smp_data   (smp_data),
        .sec_o      (sec_q),
        .lead_o     (lead_q),
        .trail_o    (trail_q),
        .both_o     (both_q)
    );

    spr_phase_map #(.DW(DW)) u_map (
        .sec   (sec_q),
        .lead  (lead_q),
        .trail (trail_q),
        .phase (mapped)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = 1'b0;
        if (top_evt) begin
            if (both_q) begin
                o_d.a    = mapped[0];
                o_d.b    = mapped[1];
                o_d.c    = mapped[2];
                o_d.vld  = 1'b1;
                o_d.miss = 1'b0;
            end else begin
                o_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign ia_o      = o_q.a;
    assign ib_o      = o_q.b;
    assign ic_o      = o_q.c;
    assign out_valid = o_q.vld;
    assign miss_o    = o_q.miss;

endmodule

// File: rtl/spr_checker.sv
module spr_checker #(
    parameter int DW = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 top_evt,
    input logic [2:0]           sec_q,
    input logic signed [DW-1:0] ia_o,
    input logic signed [DW-1:0] ib_o,
    input logic signed [DW-1:0] ic_o,
    input logic                 out_valid,
    input logic                 miss_o
);

    localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW+1:0] tri_sum;
    logic                 at_limit;

    assign tri_sum  = {{2{ia_o[DW-1]}}, ia_o} + {{2{ib_o[DW-1]}}, ib_o} + {{2{ic_o[DW-1]}}, ic_o};
    assign at_limit = (ia_o == SMAX) || (ia_o == SMIN) || (ib_o == SMAX) ||
                      (ib_o == SMIN) || (ic_o == SMAX) || (ic_o == SMIN);

    p_valid_after_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(top_evt));

    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_valid_miss_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && miss_o));

    p_hold_on_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miss_o) |-> ($stable(ia_o) && $stable(ib_o) && $stable(ic_o)));

    p_null_sector_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (($past(sec_q) == 3'd0) || ($past(sec_q) == 3'd7)))
        |-> (ia_o == '0 && ib_o == '0 && ic_o == '0));

    p_zero_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !at_limit) |-> (tri_sum == '0));

endmodule

bind shunt_phase_rebuild spr_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .top_evt   (top_evt),
    .sec_q     (sec_q),
    .ia_o      (ia_o),
    .ib_o      (ib_o),
    .ic_o      (ic_o),
    .out_valid (out_valid),
    .miss_o    (miss_o)
);

// File: tb/shunt_phase_rebuild_tb.sv
module shunt_phase_rebuild_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 12;
    localparam int VMAX = 2047;
    localparam int VMIN = -2048;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 zero_evt = 1'b0;
    logic                 top_evt = 1'b0;
    logic [2:0]           sector_in = 3'd0;
    logic                 smp_valid = 1'b0;
    logic                 smp_second = 1'b0;
    logic [DW-1:0]        smp_data = '0;
    logic signed [DW-1:0] ia_o, ib_o, ic_o;
    logic                 out_valid, miss_o;

    typedef struct {
        int    a;
        int    b;
        int    c;
        bit    v;
        bit    m;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   ha = 0, hb = 0, hc = 0;
    bit   last_top = 1'b0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shunt_phase_rebuild #(.DW(DW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .zero_evt   (zero_evt),
        .top_evt    (top_evt),
        .sector_in  (sector_in),
        .smp_valid  (smp_valid),
        .smp_second (smp_second),
        .smp_data   (smp_data),
        .ia_o       (ia_o),
        .ib_o       (ib_o),
        .ic_o       (ic_o),
        .out_valid  (out_valid),
        .miss_o     (miss_o)
    );

    function automatic int clamp(int x);
        if (x > VMAX) return VMAX;
        if (x < VMIN) return VMIN;
        return x;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // expected currents per requirement R3..R6
    task automatic model(int sec, int s1, int s2, output int a, output int b, output int c);
        int m1, m2, d;
        int ph[3];
        int lp, tp;
        m1 = s1;
        m2 = clamp(-s2);
        d  = clamp(-(m1 + m2));
        case (sec)
            1: begin lp = 1; tp = 2; end
            2: begin lp = 0; tp = 1; end
            3: begin lp = 0; tp = 2; end
            4: begin lp = 2; tp = 0; end
            5: begin lp = 1; tp = 0; end
            6: begin lp = 2; tp = 1; end
            default: begin lp = -1; tp = -1; end
        endcase
        if (lp < 0) begin
            a = 0; b = 0; c = 0;
        end else begin
            for (int i = 0; i < 3; i++) ph[i] = d;
            ph[lp] = m1;
            ph[tp] = m2;
            a = ph[0]; b = ph[1]; c = ph[2];
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send(bit second, int val);
        smp_valid  = 1'b1;
        smp_second = second;
        smp_data   = val[DW-1:0];
        tick();
        smp_valid  = 1'b0;
        tick();
    endtask

    task automatic period(int sec, int s1, int s2, bit h1, bit h2, bit rev, int later_sec, string tag);
        exp_t e;
        zero_evt  = 1'b1;
        sector_in = sec[2:0];
        tick();
        zero_evt  = 1'b0;
        sector_in = later_sec[2:0];
        tick();
        if (rev) begin
            if (h2) send(1'b1, s2);
            if (h1) send(1'b0, s1);
        end else begin
            if (h1) send(1'b0, s1);
            if (h2) send(1'b1, s2);
        end
        if (h1 && h2) begin
            model(sec, s1, s2, ha, hb, hc);
            e.v = 1'b1;
            e.m = 1'b0;
        end else begin
            e.v = 1'b0;
            e.m = 1'b1;
        end
        e.a = ha; e.b = hb; e.c = hc; e.tag = tag;
        q.push_back(e);
        top_evt = 1'b1;
        tick();
        top_evt = 1'b0;
        tick();
        tick();
    endtask

    // scoreboard monitor: result appears in the cycle after the top event
    initial begin
        forever begin
            @(negedge clk);
            if (last_top) begin
                exp_t e;
                if (q.size() == 0) begin
                    check("R7", "unexpected result", 1, 0);
                end else begin
                    e = q.pop_front();
                    check(e.tag, "out_valid", int'(out_valid), int'(e.v));
                    check(e.tag, "miss_o", int'(miss_o), int'(e.m));
                    check(e.tag, "ia", int'(ia_o), e.a);
                    check(e.tag, "ib", int'(ib_o), e.b);
                    check(e.tag, "ic", int'(ic_o), e.c);
                end
            end else if (rst_n) begin
                if (out_valid) check("R7", "strobe outside result cycle", 1, 0);
            end
            last_top = top_evt;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "ia reset", int'(ia_o), 0);
        check("R9", "ib reset", int'(ib_o), 0);
        check("R9", "ic reset", int'(ic_o), 0);
        check("R9", "valid reset", int'(out_valid), 0);
        check("R9", "miss reset", int'(miss_o), 0);
        tick();

        // R3 each active sector
        period(1, 150, 40, 1, 1, 0, 1, "R3 sector1");
        period(2, 300, -120, 1, 1, 0, 2, "R3 sector2");
        period(3, -250, 90, 1, 1, 0, 3, "R3 sector3");
        period(4, 512, 200, 1, 1, 0, 4, "R3 sector4");
        period(5, -77, -300, 1, 1, 0, 5, "R3 sector5");
        period(6, 100, 300, 1, 1, 0, 6, "R3 sector6");
        // R4 null sectors
        period(0, 400, 400, 1, 1, 0, 0, "R4 sector0");
        period(2, 33, 44, 1, 1, 0, 2, "R3 sector2 refill");
        period(7, -600, 10, 1, 1, 0, 7, "R4 sector7");
        // R2 reversed arrival
        period(4, -900, 350, 1, 1, 1, 4, "R2 reversed order");
        // R1 sector change after the zero event
        period(3, 700, 100, 1, 1, 0, 6, "R1 sector latched");
        // R6 and R5 clamping
        period(2, VMAX, VMIN, 1, 1, 0, 2, "R6 negate clamp");
        period(2, VMIN, VMAX, 1, 1, 0, 2, "R5 derived clamp high");
        period(5, VMAX, VMIN, 1, 1, 1, 5, "R5 derived clamp low");
        period(1, 20, 10, 1, 1, 0, 1, "R5 small values");
        // R8 missing readings, R10 no reuse across periods
        period(6, 111, 0, 1, 0, 0, 6, "R8 R10 second missing");
        period(6, 0, 222, 0, 1, 0, 6, "R8 R10 first missing");
        period(6, 0, 0, 0, 0, 0, 6, "R8 both missing");
        period(3, 64, -32, 1, 1, 0, 3, "R8 recovery");

        repeat (4) tick();
        check("R7", "pending results", q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule